// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This controller owns the system clock source selection, the oscillator enables and the peripheral clock enables while a device moves between RUN and two power-saving modes, HALT and STOP. It also decides when the device may leave a power-saving mode. Software drives a mode request, a wanted clock source, wanted oscillator enables and per-peripheral clock enables for low-power operation. The controller applies these settings only where they cannot make wake-up impossible without a reset.

Clock source 0 is the internal RC oscillator. Peripheral `PIN_IDX` is the pin-control and external-interrupt logic. Whatever software asks for, the RC oscillator stays on outside RUN, the pin-control clock is never gated, and STOP always runs the system on the RC oscillator. When the device leaves STOP, the controller moves back to the clock source that was in use before STOP, but only once that source reports that it is running. The glitch-free switch cell, the oscillators and the register bus lie outside the block.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: `mode` reports RUN=0, HALT=1, STOP=2. In RUN, a request with `mode_req_valid`=1 and `mode_req`=1 enters HALT at the next edge, and `mode_req`=2 enters STOP at the next edge. Codes 0 and 3 are ignored.
- R2: In RUN every bit of `periph_clk_en` is 1. In HALT and STOP, `periph_clk_en` follows `periph_lp_en`, except that bit `PIN_IDX` (0 by default) stays 1.
- R3: In RUN, `osc_en` equals `osc_en_cfg`. Outside RUN, `osc_en[0]` (the RC oscillator) and the bit of the currently selected source are forced to 1, whatever `osc_en_cfg` requests.
- R4: The edge that enters STOP sets `sys_sel` to 0, and `sys_sel` stays 0 for as long as STOP lasts.
- R5: In RUN, `sys_sel` takes `sys_sel_cfg` one edge later. In HALT, `sys_sel` takes `sys_sel_cfg` only when `src_running[sys_sel_cfg]` is 1. Otherwise it keeps its value.
- R6: In HALT or STOP, the device wakes at the next edge when an `ext_irq` bit is set whose `ext_irq_mask` bit is 0, or when a `periph_irq` bit is set whose `periph_clk_en` bit is 1. Masked pins and peripherals with a gated clock do not wake it.
- R7: A pulse on `nmi_en_set` arms the NMI until reset. Once armed, `nmi` wakes the device from HALT or STOP. Before it is armed, `nmi` has no effect.
- R8: On wake from STOP, `mode` reads 0. `sys_sel` returns to the source used before STOP as soon as that source's `src_running` bit is 1. Until then, `sys_sel` stays 0 and that source's `osc_en` bit is forced to 1.
- R9: Mode requests are ignored in HALT, in STOP and while the controller waits for the restored source to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode code |
| sys_sel_cfg | input | SEL_W | Software-wanted system clock source |
| src_running | input | N_SRC | Per-source running indication |
| osc_en_cfg | input | N_SRC | Software-wanted oscillator enables |
| periph_lp_en | input | N_PERIPH | Peripheral clock enables used in low-power modes |
| ext_irq | input | N_EXT | External interrupt pin events |
| ext_irq_mask | input | N_EXT | Pin masks, 1 = masked |
| periph_irq | input | N_PERIPH | Peripheral interrupt lines |
| nmi_en_set | input | 1 | Arms the NMI (set-only) |
| nmi | input | 1 | Non-maskable interrupt |
| sys_sel | output | SEL_W | System clock mux select |
| osc_en | output | N_SRC | Oscillator enables |
| periph_clk_en | output | N_PERIPH | Peripheral clock enables |
| mode | output | 2 | Current mode |

## Verification
The hardest state to reach is the wait after leaving STOP. In that state `mode` already reads RUN, but the source saved before STOP is not yet running. The stimulus turns off `src_running` for the saved source while the device is in STOP. It then wakes the device through an unmasked pin and holds the controller there while mode requests arrive and are ignored. Finally it restores the running bit and observes the selection return. A behavioural model compares every output on every cycle throughout.

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl #(
  parameter int N_SRC    = 4,
  parameter int N_PERIPH = 8,
  parameter int N_EXT    = 4,
  parameter int PIN_IDX  = 0,
  parameter int SEL_W    = $clog2(N_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_req_valid,
  input  logic [1:0]          mode_req,
  input  logic [SEL_W-1:0]    sys_sel_cfg,
  input  logic [N_SRC-1:0]    src_running,
  input  logic [N_SRC-1:0]    osc_en_cfg,
  input  logic [N_PERIPH-1:0] periph_lp_en,
  input  logic [N_EXT-1:0]    ext_irq,
  input  logic [N_EXT-1:0]    ext_irq_mask,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic                nmi_en_set,
  input  logic                nmi,
  output logic [SEL_W-1:0]    sys_sel,
  output logic [N_SRC-1:0]    osc_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic [1:0]          mode
);

  localparam logic [N_PERIPH-1:0] PIN_MASK = N_PERIPH'(1) << PIN_IDX;
  localparam logic [N_SRC-1:0]    IRC_MASK = N_SRC'(1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_HALT = 2'd1, S_STOP = 2'd2, S_WAKE = 2'd3} state_t;

  state_t           state_q;
  logic [SEL_W-1:0] sel_q, saved_q;
  logic             nmi_arm_q;
  logic             low_pwr, wake, saved_ok;
  logic [N_SRC-1:0] sel_oh, saved_oh;

  assign low_pwr       = (state_q == S_HALT) || (state_q == S_STOP);
  assign periph_clk_en = low_pwr ? (periph_lp_en | PIN_MASK) : '1;
  assign wake          = |(ext_irq & ~ext_irq_mask) | |(periph_irq & periph_clk_en) | (nmi & nmi_arm_q);
  assign saved_ok      = src_running[saved_q];
  assign sel_oh        = N_SRC'(1) << sel_q;
  assign saved_oh      = N_SRC'(1) << saved_q;
  assign osc_en        = (state_q == S_RUN) ? osc_en_cfg :
                         (osc_en_cfg | IRC_MASK | sel_oh | ((state_q == S_WAKE) ? saved_oh : '0));
  assign mode          = (state_q == S_WAKE) ? 2'd0 : 2'(state_q);
  assign sys_sel       = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_RUN;
      sel_q     <= '0;
      saved_q   <= '0;
      nmi_arm_q <= 1'b0;
    end else begin
      nmi_arm_q <= nmi_arm_q | nmi_en_set;
      case (state_q)
        S_RUN: begin
          sel_q <= sys_sel_cfg;
          if (mode_req_valid && mode_req == 2'd1) begin
            state_q <= S_HALT;
          end else if (mode_req_valid && mode_req == 2'd2) begin
            state_q <= S_STOP;
            saved_q <= sel_q;
            sel_q   <= '0;
          end
        end
        S_HALT: begin
          if (src_running[sys_sel_cfg]) sel_q <= sys_sel_cfg;
          if (wake) state_q <= S_RUN;
        end
        S_STOP: begin
          if (wake) begin
            if (saved_ok) begin
              state_q <= S_RUN;
              sel_q   <= saved_q;
            end else begin
              state_q <= S_WAKE;
            end
          end
        end
        default: begin
          if (saved_ok) begin
            state_q <= S_RUN;
            sel_q   <= saved_q;
          end
        end
      endcase
    end
  end

  AST_STOP_ON_IRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (sys_sel == '0)); // R4

  AST_IRC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> osc_en[0]); // R3

  AST_PIN_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    periph_clk_en[PIN_IDX]); // R2

  AST_HALT_NO_DEAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HALT && !src_running[sys_sel_cfg]) |=> (sys_sel == $past(sys_sel))); // R5

  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_arm_q |=> nmi_arm_q); // R7

  AST_WAIT_ON_IRC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAKE) |-> (sys_sel == '0 && mode == 2'd0 && osc_en[saved_q])); // R8

  AST_LP_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOP && !wake) |=> (state_q == S_STOP)); // R9

endmodule

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, NP = 8, NE = 4;

  logic clk = 0, rst_n = 0;
  logic mode_req_valid = 0, nmi_en_set = 0, nmi = 0;
  logic [1:0] mode_req = 0;
  logic [1:0] sys_sel_cfg = 2;
  logic [NS-1:0] src_running = 4'b1111, osc_en_cfg = 4'b0110;
  logic [NP-1:0] periph_lp_en = 8'b0000_0100, periph_irq = 0;
  logic [NE-1:0] ext_irq = 0, ext_irq_mask = 4'b1111;
  logic [1:0] sys_sel, mode;
  logic [NS-1:0] osc_en;
  logic [NP-1:0] periph_clk_en;

  int checks = 0, errors = 0, cyc = 0;
  int ms = 0, msel = 0, msav = 0, mnmi = 0;

  lpm_clk_ctrl #(.N_SRC(NS), .N_PERIPH(NP), .N_EXT(NE), .PIN_IDX(0)) dut (
    .clk(clk), .rst_n(rst_n), .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .sys_sel_cfg(sys_sel_cfg), .src_running(src_running), .osc_en_cfg(osc_en_cfg),
    .periph_lp_en(periph_lp_en), .ext_irq(ext_irq), .ext_irq_mask(ext_irq_mask),
    .periph_irq(periph_irq), .nmi_en_set(nmi_en_set), .nmi(nmi),
    .sys_sel(sys_sel), .osc_en(osc_en), .periph_clk_en(periph_clk_en), .mode(mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NP-1:0] e_periph(int st);
    if (st == 1 || st == 2) return periph_lp_en | 8'h01;
    return '1;
  endfunction

  function automatic logic [NS-1:0] e_osc(int st, int sel, int sav);
    logic [NS-1:0] r;
    r = osc_en_cfg;
    if (st != 0) begin
      r[0] = 1'b1;
      r[sel] = 1'b1;
      if (st == 3) r[sav] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; msel = 0; msav = 0; mnmi = 0;
    end else begin
      bit w;
      logic [NP-1:0] pe;
      w = 0;
      pe = e_periph(ms);
      for (int i = 0; i < NE; i++) if (ext_irq[i] && !ext_irq_mask[i]) w = 1;
      for (int p = 0; p < NP; p++) if (periph_irq[p] && pe[p]) w = 1;
      if (nmi && mnmi != 0) w = 1;
      if (nmi_en_set) mnmi = 1;
      if (ms == 0) begin
        if (mode_req_valid && mode_req == 2'd1) begin
          ms = 1; msel = sys_sel_cfg;
        end else if (mode_req_valid && mode_req == 2'd2) begin
          ms = 2; msav = msel; msel = 0;
        end else msel = sys_sel_cfg;
      end else if (ms == 1) begin
        if (src_running[sys_sel_cfg]) msel = sys_sel_cfg;
        if (w) ms = 0;
      end else if (ms == 2) begin
        if (w) begin
          if (src_running[msav]) begin ms = 0; msel = msav; end
          else ms = 3;
        end
      end else begin
        if (src_running[msav]) begin ms = 0; msel = msav; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 mode", mode, (ms == 3) ? 0 : ms);
      chk("R5 sys_sel", sys_sel, msel);
      chk("R3 osc_en", osc_en, e_osc(ms, msel, msav));
      chk("R2 periph_clk_en", periph_clk_en, e_periph(ms));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic req(input logic [1:0] m);
    mode_req = m; mode_req_valid = 1; step(1); mode_req_valid = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3); rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R5 reset sys_sel", sys_sel, 0);
    step(1); @(negedge clk);
    chk("R5 RUN follows cfg", sys_sel, 2);
    chk("R3 RUN osc follows cfg", osc_en, 4'b0110);

    req(2); @(negedge clk);
    chk("R1 STOP entered", mode, 2);
    chk("R4 STOP on IRC", sys_sel, 0);
    chk("R3 IRC forced on", osc_en[0], 1);
    chk("R2 lp gating plus pin clock", periph_clk_en, 8'b0000_0101);

    ext_irq = 4'b0010; step(2); @(negedge clk);
    chk("R6 masked pin ignored", mode, 2);
    ext_irq = 0; periph_irq = 8'b1000_0000; step(2); @(negedge clk);
    chk("R6 gated peripheral ignored", mode, 2);
    periph_irq = 0; nmi = 1; step(2); @(negedge clk);
    chk("R7 unarmed NMI ignored", mode, 2);
    nmi = 0; req(1); @(negedge clk);
    chk("R9 request in STOP ignored", mode, 2);

    osc_en_cfg = 0; src_running = 4'b1011; ext_irq_mask = 4'b1101; ext_irq = 4'b0010;
    step(1); @(negedge clk);
    chk("R8 wait mode RUN", mode, 0);
    chk("R8 wait on IRC", sys_sel, 0);
    chk("R8 saved osc forced", osc_en[2], 1);
    ext_irq = 0; ext_irq_mask = 4'b1111;
    req(2); step(1); @(negedge clk);
    chk("R9 request in wait ignored", mode, 0);
    chk("R8 still on IRC", sys_sel, 0);
    src_running = 4'b1111; step(1); @(negedge clk);
    chk("R8 selection restored", sys_sel, 2);

    req(1); @(negedge clk);
    chk("R1 HALT entered", mode, 1);
    chk("R3 HALT osc forced", osc_en, 4'b0101);
    src_running = 4'b0111; sys_sel_cfg = 3; step(2); @(negedge clk);
    chk("R5 dead clock refused", sys_sel, 2);
    src_running = 4'b1111; step(1); @(negedge clk);
    chk("R5 running clock accepted", sys_sel, 3);
    periph_irq = 8'b0000_0100; step(1); @(negedge clk);
    chk("R6 clocked peripheral wakes", mode, 0);
    periph_irq = 0;

    nmi_en_set = 1; step(1); nmi_en_set = 0;
    req(1); nmi = 1; step(1); @(negedge clk);
    chk("R7 armed NMI wakes HALT", mode, 0);
    nmi = 0; req(2); step(1); @(negedge clk);
    chk("R7 still armed", mode, 2);
    nmi = 1; step(1); nmi = 0; @(negedge clk);
    chk("R7 NMI wakes STOP", mode, 0);
    chk("R8 immediate restore", sys_sel, 3);

    req(3); @(negedge clk);
    chk("R1 code 3 ignored", mode, 0);
    req(0); @(negedge clk);
    chk("R1 code 0 ignored", mode, 0);

    periph_lp_en = 0; req(2); periph_irq = 8'b0000_0001; step(1); @(negedge clk);
    chk("R2 pin peripheral still wakes", mode, 0);
    periph_irq = 0; step(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule